// File: doc/BRIEF.md
# Sampling Tap Window Selector

After a sampling-phase sweep, every tap of a delay line has been probed twice, once in each of two passes. The results arrive as two bitmasks, one bit per probe. The pass mask records whether each probe transfer succeeded. The match mask records whether the sampled data agreed with the reference comparison. This block turns those masks into one tap choice.

The block first folds the two passes of each tap together, so a tap counts only when both of its probes are good. It then walks the folded pass mask one bit per clock and keeps the longest unbroken run of good probes. The tap at the centre of that run is reported, reduced modulo the tap count. There is one special case: when every probe passed, the pass mask gives no information about position, and the longest run of the match mask decides instead. The result is either a valid tap together with a retune enable, or an error flag that leaves the previous tap in place.

The block is used once per tuning attempt. A controller loads the masks and the tap count, pulses `start`, waits for `done`, and then reads `sel_ok`, `sel_err` and `tap_sel`.

Top module: `sts_window_sel`

## Requirements
- R1: After synchronous reset, `tap_sel` is 0, and `retune_en`, `busy`, `done`, `sel_ok` and `sel_err` are all 0.
- R2: `half_taps`=0 selects N=8 taps and `half_taps`=1 selects N=4 taps. Mask bit i belongs to the probe of tap i mod N, for i from 0 to 2N-1. Bit k and bit k+N are treated as good only if both are 1 in the raw mask. This folding applies to each mask separately.
- R3: The longest run of consecutive ones in the folded pass mask is found scanning from bit 0 upward. Among runs of equal greatest length, the lowest one wins.
- R4: A run that reaches bit 2N-1 is counted. Runs do not wrap from bit 2N-1 back to bit 0.
- R5: If the longest pass run covers all 2N bits, the longest run of the folded match mask (same rules as R3 and R4) is used instead. If that mask has no ones, the result is an error.
- R6: If the longest pass run is shorter than 2N, a tap is selected only when the run has at least MIN_RUN (default 3) bits. Otherwise the result is an error.
- R7: The selected tap is ((first + last) / 2) mod N, using integer division, where first and last are the bit positions at the two ends of the chosen run.
- R8: On success, `sel_ok` and `retune_en` go to 1 and `tap_sel` takes the new tap. On error, `sel_err` goes to 1, `retune_en` goes to 0 and `tap_sel` keeps its previous value. `sel_ok` and `sel_err` are never both 1.
- R9: `start` is sampled on a clock edge while the block is idle. `done` is a one-cycle pulse that appears 2N+1 edges after that edge, and `busy` is high in between. `sel_ok` and `sel_err` hold their values until the next accepted `start`, which clears them.
- R10: While `busy` is high, `start` and any change of the mask inputs have no effect on the result. In 4-tap mode, mask bits 8 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection; sampled only while idle |
| half_taps | input | 1 | 0: 8 taps, 1: 4 taps |
| pass_mask | input | 16 | Per-probe transfer success, bit i is the probe at tap i mod N |
| match_mask | input | 16 | Per-probe data-match result, same bit layout |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_ok | output | 1 | Last selection succeeded |
| sel_err | output | 1 | Last selection failed |
| tap_sel | output | 3 | Selected sampling tap |
| retune_en | output | 1 | Automatic retune enable, set on success |

## Verification
Some properties are checked on every cycle. `done` lasts exactly one cycle and follows a busy period. The two result flags are never both set. A failed selection leaves the tap untouched, and a success raises the retune enable. In 4-tap mode a valid tap stays below 4. Inside each run tracker, the recorded best run has a length that matches its end positions, and that length never shrinks during a scan. Whether the chosen tap is the right one can only be shown by the bench scenarios: tie-breaking between equal runs, a run ending at the top bit, the hand-off to the match mask, and the minimum-length threshold. These scenarios compare the block against an arithmetic model over exhaustive 4-tap sweeps and broad 8-tap sweeps, and they also cover the exact latency and the inputs that must be ignored.

// File: rtl/sts_pkg.sv
package sts_pkg;

    localparam int unsigned TAPS_MAX   = 8;
    localparam int unsigned TAPS_HALF  = TAPS_MAX / 2;
    localparam int unsigned PROBES_MAX = 2 * TAPS_MAX;
    localparam int unsigned IDX_W      = $clog2(PROBES_MAX);
    localparam int unsigned LEN_W      = IDX_W + 1;
    localparam int unsigned TAP_W      = $clog2(TAPS_MAX);
    localparam int unsigned LANES      = 2;   // lane 0: pass, lane 1: match

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SCAN   = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
    } run_t;

    // Fold the two passes of each tap: a probe stays good only if its twin is good too.
    function automatic logic [PROBES_MAX-1:0] fold_mask(
        input logic [PROBES_MAX-1:0] raw,
        input logic                  half
    );
        logic [PROBES_MAX-1:0] res;
        res = '0;
        if (half) begin
            for (int k = 0; k < int'(TAPS_HALF); k++) begin
                res[k]             = raw[k] & raw[k + TAPS_HALF];
                res[k + TAPS_HALF] = res[k];
            end
        end else begin
            for (int k = 0; k < int'(TAPS_MAX); k++) begin
                res[k]            = raw[k] & raw[k + TAPS_MAX];
                res[k + TAPS_MAX] = res[k];
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sts_run_tracker.sv
module sts_run_tracker
    import sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    input  logic [IDX_W-1:0] idx,
    input  logic             last,
    output run_t             best
);

    logic [LEN_W-1:0] cur;
    logic [LEN_W-1:0] cur_inc;

    assign cur_inc = cur + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur  <= '0;
            best <= '0;
        end else if (step) begin
            if (!bit_in) begin
                if (cur > best.len) begin
                    best.len   <= cur;
                    best.first <= idx - cur[IDX_W-1:0];
                    best.last  <= idx - IDX_W'(1);
                end
                cur <= '0;
            end else if (last) begin
                // run closed by the top bit of the mask
                if (cur_inc > best.len) begin
                    best.len   <= cur_inc;
                    best.first <= idx - cur[IDX_W-1:0];
                    best.last  <= idx;
                end
                cur <= '0;
            end else begin
                cur <= cur_inc;
            end
        end
    end

    // R3: a recorded run spans exactly its length
    assert_run_span_R3: assert property (@(posedge clk) disable iff (rst)
        (best.len != '0) |->
        (({1'b0, best.last} - {1'b0, best.first}) == (best.len - LEN_W'(1))));

    // R3: the best run never shrinks during a scan
    assert_run_grows_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (best.len >= $past(best.len)));

endmodule

// File: rtl/sts_pick.sv
module sts_pick
    import sts_pkg::*;
#(
    parameter int unsigned MIN_RUN = 3
) (
    input  logic             half,
    input  run_t             pass_run,
    input  run_t             match_run,
    output logic             ok,
    output logic [TAP_W-1:0] tap
);

    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(PROBES_MAX);
    localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(PROBES_MAX / 2);
    localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_RUN);
    localparam logic [IDX_W-1:0] WRAP_FULL = IDX_W'(TAPS_MAX - 1);
    localparam logic [IDX_W-1:0] WRAP_HALF = IDX_W'(TAPS_HALF - 1);

    logic             all_pass;
    run_t             chosen;
    logic [LEN_W-1:0] span_sum;
    logic [IDX_W-1:0] centre;

    always_comb begin
        all_pass = (pass_run.len == (half ? LEN_HALF : LEN_FULL));
        chosen   = all_pass ? match_run : pass_run;
        ok       = all_pass ? (match_run.len != '0) : (pass_run.len >= LEN_MIN);
        span_sum = {1'b0, chosen.first} + {1'b0, chosen.last};
        centre   = IDX_W'(span_sum >> 1);
        tap      = TAP_W'(centre & (half ? WRAP_HALF : WRAP_FULL));
    end

endmodule

// File: rtl/sts_window_sel.sv
module sts_window_sel
    import sts_pkg::*;
#(
    parameter int unsigned MIN_RUN = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  half_taps,
    input  logic [PROBES_MAX-1:0] pass_mask,
    input  logic [PROBES_MAX-1:0] match_mask,
    output logic                  busy,
    output logic                  done,
    output logic                  sel_ok,
    output logic                  sel_err,
    output logic [TAP_W-1:0]      tap_sel,
    output logic                  retune_en
);

    localparam logic [IDX_W-1:0] TOP_FULL = IDX_W'(PROBES_MAX - 1);
    localparam logic [IDX_W-1:0] TOP_HALF = IDX_W'(PROBES_MAX / 2 - 1);

    phase_e                            phase;
    logic [IDX_W-1:0]                  idx;
    logic                              half_q;
    logic [LANES-1:0][PROBES_MAX-1:0]  lane_q;
    logic                              accept;
    logic                              scan_step;
    logic                              scan_last;
    run_t                              lane_run [LANES];
    logic                              pick_ok;
    logic [TAP_W-1:0]                  pick_tap;

    assign accept    = (phase == PH_IDLE) && start;
    assign scan_step = (phase == PH_SCAN);
    assign scan_last = scan_step && (idx == (half_q ? TOP_HALF : TOP_FULL));
    assign busy      = (phase != PH_IDLE);

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        sts_run_tracker u_trk (
            .clk    (clk),
            .rst    (rst),
            .clear  (accept),
            .step   (scan_step),
            .bit_in (lane_q[g][idx]),
            .idx    (idx),
            .last   (scan_last),
            .best   (lane_run[g])
        );
    end

    sts_pick #(.MIN_RUN(MIN_RUN)) u_pick (
        .half      (half_q),
        .pass_run  (lane_run[0]),
        .match_run (lane_run[1]),
        .ok        (pick_ok),
        .tap       (pick_tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            idx       <= '0;
            half_q    <= 1'b0;
            lane_q    <= '0;
            done      <= 1'b0;
            sel_ok    <= 1'b0;
            sel_err   <= 1'b0;
            tap_sel   <= '0;
            retune_en <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        half_q    <= half_taps;
                        lane_q[0] <= fold_mask(pass_mask, half_taps);
                        lane_q[1] <= fold_mask(match_mask, half_taps);
                        idx       <= '0;
                        sel_ok    <= 1'b0;
                        sel_err   <= 1'b0;
                        phase     <= PH_SCAN;
                    end
                end
                PH_SCAN: begin
                    idx <= idx + IDX_W'(1);
                    if (scan_last) begin
                        phase <= PH_DECIDE;
                    end
                end
                PH_DECIDE: begin
                    done      <= 1'b1;
                    sel_ok    <= pick_ok;
                    sel_err   <= !pick_ok;
                    retune_en <= pick_ok;
                    if (pick_ok) begin
                        tap_sel <= pick_tap;
                    end
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(sel_ok && sel_err));

    assert_err_keeps_tap_R8: assert property (@(posedge clk) disable iff (rst)
        (done && sel_err) |-> (tap_sel == $past(tap_sel)));

    assert_ok_retune_R8: assert property (@(posedge clk) disable iff (rst)
        (done && sel_ok) |-> retune_en);

    assert_half_tap_range_R2: assert property (@(posedge clk) disable iff (rst)
        (done && sel_ok && half_q) |-> (tap_sel < TAP_W'(TAPS_HALF)));

endmodule

// File: tb/sts_window_sel_tb.sv
module sts_window_sel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        half_taps;
    logic [15:0] pass_mask;
    logic [15:0] match_mask;
    logic        busy, done, sel_ok, sel_err, retune_en;
    logic [2:0]  tap_sel;

    int n_checks = 0;
    int n_fail   = 0;
    int prev_tap = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;   // 125 MHz

    sts_window_sel u_dut (
        .clk(clk), .rst(rst), .start(start), .half_taps(half_taps),
        .pass_mask(pass_mask), .match_mask(match_mask),
        .busy(busy), .done(done), .sel_ok(sel_ok), .sel_err(sel_err),
        .tap_sel(tap_sel), .retune_en(retune_en)
    );

    function automatic logic [31:0] rnd(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // longest run of ones, lowest start wins ties, no wrap
    task automatic longest(input logic [15:0] m, input int w, output int st, output int ln);
        ln = 0;
        st = 0;
        for (int s = 0; s < w; s++) begin
            int l;
            l = 0;
            while ((s + l) < w && m[s + l]) l++;
            if (l > ln) begin
                ln = l;
                st = s;
            end
        end
    endtask

    task automatic model(input int n, input logic [15:0] p, input logic [15:0] m,
                         output bit ok, output int tap);
        logic [15:0] fp, fm;
        int ps, pl, ms, ml, s, l;
        fp = '0;
        fm = '0;
        for (int k = 0; k < n; k++) begin
            fp[k] = p[k] & p[k + n];  fp[k + n] = fp[k];
            fm[k] = m[k] & m[k + n];  fm[k + n] = fm[k];
        end
        longest(fp, 2 * n, ps, pl);
        longest(fm, 2 * n, ms, ml);
        if (pl == 2 * n) begin
            ok = (ml > 0); s = ms; l = ml;
        end else begin
            ok = (pl >= 3); s = ps; l = pl;
        end
        tap = ok ? (((s + s + l - 1) / 2) % n) : prev_tap;
    endtask

    task automatic run_case(input bit half, input logic [15:0] p, input logic [15:0] m,
                            input bit disturb, input string req);
        int n, lat, exp_tap;
        bit exp_ok;
        n = half ? 4 : 8;
        model(n, p, m, exp_ok, exp_tap);
        @(negedge clk);
        half_taps = half; pass_mask = p; match_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            if (disturb && lat == 2) begin
                start = 1'b1; half_taps = ~half; pass_mask = ~p; match_mask = ~m;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check("R9", "done latency", lat, 2 * n + 1);
        check(req, "tap_sel", int'(tap_sel), exp_tap);
        check(req, "sel_ok", int'(sel_ok), int'(exp_ok));
        check("R8", "sel_err", int'(sel_err), int'(!exp_ok));
        check("R8", "retune_en", int'(retune_en), int'(exp_ok));
        if (disturb) check("R10", "result under busy start", int'(sel_ok), int'(exp_ok));
        @(negedge clk);
        check("R9", "done pulse width", int'(done), 0);
        check("R9", "sel_ok held", int'(sel_ok), int'(exp_ok));
        prev_tap = exp_tap;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; half_taps = 1'b0; pass_mask = '0; match_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "tap_sel", int'(tap_sel), 0);
        check("R1", "retune_en", int'(retune_en), 0);
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "sel_ok", int'(sel_ok), 0);
        check("R1", "sel_err", int'(sel_err), 0);

        // directed: tie goes to lowest run (R3), run ending at top bit (R4)
        run_case(1'b0, 16'h7777, 16'h0000, 1'b0, "R3");
        run_case(1'b0, 16'hE7E7, 16'h0000, 1'b0, "R3");
        run_case(1'b0, 16'hF0F0, 16'h0000, 1'b0, "R4");
        run_case(1'b1, 16'h00CC, 16'h0000, 1'b0, "R4");
        run_case(1'b0, 16'h0303, 16'h0000, 1'b0, "R6");
        run_case(1'b0, 16'hFFFF, 16'h0000, 1'b0, "R5");
        run_case(1'b0, 16'hFFFF, 16'h3C3C, 1'b0, "R5");
        run_case(1'b0, 16'h0FF0, 16'hFFFF, 1'b0, "R2");

        // 4-tap: every pass mask, upper byte noise (R10)
        for (int pv = 0; pv < 256; pv++) begin
            for (int mi = 0; mi < 3; mi++) begin
                logic [15:0] pm, mm;
                lfsr = rnd(lfsr);
                pm = {lfsr[15:8], 8'(pv)};
                mm = {lfsr[31:24], lfsr[23:16]};
                run_case(1'b1, pm, mm, (pv % 9) == 0, "R2/R6/R7/R10");
            end
        end
        // 4-tap all pass: every match mask decides (R5)
        for (int mv = 0; mv < 256; mv++) begin
            lfsr = rnd(lfsr);
            run_case(1'b1, {lfsr[7:0], 8'hFF}, {lfsr[15:8], 8'(mv)}, 1'b0, "R5/R7");
        end
        // 8-tap: folded-equal halves
        for (int b = 0; b < 256; b++) begin
            lfsr = rnd(lfsr);
            run_case(1'b0, {8'(b), 8'(b)}, lfsr[15:0], (b % 11) == 0, "R3/R4/R6/R7");
        end
        // 8-tap all pass, match sweep
        for (int b = 0; b < 256; b++) begin
            run_case(1'b0, 16'hFFFF, {8'(b), 8'(b)}, 1'b0, "R5/R7");
        end
        // 8-tap random masks, unequal halves
        for (int r = 0; r < 400; r++) begin
            lfsr = rnd(lfsr);
            run_case(1'b0, lfsr[15:0] | lfsr[31:16], lfsr[31:16], 1'b0, "R2/R3/R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule